// File: doc/BRIEF.md
# Programmable Counter Array Timebase

This block is the shared 16-bit timebase for a bank of five compare/capture modules. A free-running up-counter advances on one of four selectable count sources: the oscillator divided by twelve, the oscillator divided by four, a timer-0 overflow pulse, or the falling edges of an external pin. The pin is synchronised and sampled once every four oscillator clocks, so it is only guaranteed to count at rates up to fosc/8. Counting is gated by a run bit and, optionally, by the chip's idle indication.

Two byte-wide registers control the block and are written through a simple port. A mode register holds the idle gate, a watchdog enable that is passed on to module 4, the source select and the overflow interrupt enable. A control register holds the overflow flag, the run bit and one event flag per module. Hardware sets the flags and only software clears them. A single interrupt request combines the enabled overflow flag with the five module flags.

Top module: `pca_timebase`

## Requirements
- R1: After a synchronous reset, `mode_q` and `ctrl_q` read 0x00, `count_q` is 0, and `irq` and `wdt_en` are 0.
- R2: A write with `wr_sel`=0 loads the mode register. Bit 7 is the idle gate, bit 6 drives `wdt_en`, bits 2:1 are the source select and bit 0 is the overflow interrupt enable. Bits 5:3 of `mode_q` and bit 5 of `ctrl_q` always read 0.
- R3: With source 00 the counter advances on every clock edge k that is a multiple of 12, and with source 01 on every edge k that is a multiple of 4. Edges are numbered from k=1, the first rising edge after reset is released, because the prescaler runs freely from reset.
- R4: With source 10 the counter advances by one on each clock edge at which `t0_ovf` is high.
- R5: With source 11 the counter advances once for each falling edge of `ext_pin`, provided the pin holds each level for at least 8 clocks.
- R6: The counter advances only while the run bit (`ctrl_q` bit 6) is 1. A write with `wr_sel`=1 sets or clears the run bit, and the change takes effect from the next edge.
- R7: When mode bit 7 is 1 and `idle` is high, the counter holds its value. When mode bit 7 is 0, `idle` has no effect.
- R8: When the counter advances from 0xFFFF it wraps to 0, and in the same edge it sets the overflow flag (`ctrl_q` bit 7).
- R9: A control write of 1 to bit 7 sets the overflow flag, and only a control write of 0 to bit 7 clears it. A pulse on `mod_evt[i]` sets `ctrl_q` bit i (i = 0..4). A control write of 0 to bit i clears that flag, and writing 1 to bit i leaves it unchanged.
- R10: When a hardware set and a software clear of the same flag fall in the same edge, the flag ends up set.
- R11: `irq` is 1 exactly when (overflow flag AND mode bit 0) OR any module flag is 1, and it changes in the same edge as those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mode, 1 control |
| wr_data | input | 8 | Write data |
| t0_ovf | input | 1 | Timer-0 overflow pulse |
| ext_pin | input | 1 | External count pin (asynchronous) |
| idle | input | 1 | Chip idle indication |
| mod_evt | input | 5 | Per-module match/capture event pulses |
| mode_q | output | 8 | Mode register read value |
| ctrl_q | output | 8 | Control register read value |
| count_q | output | 16 | Timebase count |
| wdt_en | output | 1 | Watchdog enable for module 4 |
| irq | output | 1 | Interrupt request |

## Verification
The count function is tried with each source select over windows of known length. Each window starts from the same reset phase, so a divider of 12, 4 or 3 (a periodic timer-0 pulse) gives a distinct, predictable total, and a wrong source decode or prescaler phase shows up as a wrong count. The same windows are repeated with the run bit off and with idle asserted under both settings of the idle gate, which separates run gating from idle gating. A slow external square wave checks the edge counting. A long run driven by timer-0 checks the wrap. Directed flag sequences, including a clear that coincides with an event, separate the set, clear and priority rules and the interrupt masking.

// File: rtl/pca_pkg.sv
package pca_pkg;
  typedef enum logic [1:0] {
    SRC_DIV12 = 2'b00,
    SRC_DIV4  = 2'b01,
    SRC_T0    = 2'b10,
    SRC_EXT   = 2'b11
  } src_e;

  localparam int MODE_IDLE_GATE = 7;
  localparam int MODE_WDT       = 6;
  localparam int MODE_SRC_HI    = 2;
  localparam int MODE_SRC_LO    = 1;
  localparam int MODE_OVF_IE    = 0;

  localparam int CTRL_OVF = 7;
  localparam int CTRL_RUN = 6;
endpackage

// File: rtl/pca_src_sel.sv
module pca_src_sel
  import pca_pkg::*;
#(
  parameter int PRE_DIV  = 12,
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  src_e src,
  input  logic t0_ovf,
  input  logic ext_pin,
  output logic tick
);
  localparam int PW = $clog2(PRE_DIV);
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRE_DIV - 1);
  localparam logic [PW-1:0] FAST_MOD  = PW'(FAST_DIV);
  localparam logic [PW-1:0] FAST_LAST = PW'(FAST_DIV - 1);

  logic [PW-1:0] pre_q;
  logic          slow_ph, fast_ph;
  logic          ext_s1, ext_s2, ext_prev, ext_fall;

  // free-running prescaler, phase aligned to reset release
  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (pre_q == PRE_LAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  assign slow_ph = (pre_q == PRE_LAST);
  assign fast_ph = ((pre_q % FAST_MOD) == FAST_LAST);

  // two-stage synchroniser, then a sample once per fast phase
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_s1   <= 1'b0;
      ext_s2   <= 1'b0;
      ext_prev <= 1'b0;
    end else begin
      ext_s1 <= ext_pin;
      ext_s2 <= ext_s1;
      if (fast_ph) ext_prev <= ext_s2;
    end
  end

  assign ext_fall = fast_ph & ext_prev & ~ext_s2;

  always_comb begin
    unique case (src)
      SRC_DIV12: tick = slow_ph;
      SRC_DIV4:  tick = fast_ph;
      SRC_T0:    tick = t0_ovf;
      SRC_EXT:   tick = ext_fall;
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/pca_counter.sv
module pca_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  output logic [CNT_W-1:0] count_q,
  output logic             wrap
);
  logic step;
  logic armed;

  assign step = tick & en;
  assign wrap = step & (count_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else if (step) count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk) armed <= ~rst;

  // R3: the timebase only ever moves forward by one
  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    (count_q != $past(count_q)) |-> (count_q == $past(count_q) + 1'b1));

  // R8: a wrap returns the count to zero
  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (count_q == '0));
endmodule

// File: rtl/pca_regs.sv
module pca_regs
  import pca_pkg::*;
#(
  parameter int NUM_MOD = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [7:0]         wr_data,
  input  logic               wrap,
  input  logic [NUM_MOD-1:0] mod_evt,
  output logic [7:0]         mode_q,
  output logic [7:0]         ctrl_q,
  output logic               irq
);
  localparam int PAD = 6 - NUM_MOD;

  logic               idle_gate, wdt, ovf_ie, run, ovf;
  src_e               src;
  logic [NUM_MOD-1:0] flg;
  logic               mode_wr, ctrl_wr;
  logic               ovf_nx, ie_nx;
  logic [NUM_MOD-1:0] flg_nx;
  logic               unused_rsvd;
  logic               armed;

  assign mode_wr = wr_en & ~wr_sel;
  assign ctrl_wr = wr_en &  wr_sel;
  assign unused_rsvd = ^wr_data[5:3];

  // hardware set dominates a software write in the same edge
  assign ovf_nx = wrap | (ctrl_wr ? wr_data[CTRL_OVF] : ovf);
  assign ie_nx  = mode_wr ? wr_data[MODE_OVF_IE] : ovf_ie;

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_flag
    assign flg_nx[i] = mod_evt[i] | (ctrl_wr ? (flg[i] & wr_data[i]) : flg[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_gate <= 1'b0;
      wdt       <= 1'b0;
      src       <= SRC_DIV12;
      ovf_ie    <= 1'b0;
      run       <= 1'b0;
      ovf       <= 1'b0;
      flg       <= '0;
      irq       <= 1'b0;
    end else begin
      if (mode_wr) begin
        idle_gate <= wr_data[MODE_IDLE_GATE];
        wdt       <= wr_data[MODE_WDT];
        src       <= src_e'(wr_data[MODE_SRC_HI:MODE_SRC_LO]);
      end
      if (ctrl_wr) run <= wr_data[CTRL_RUN];
      ovf_ie <= ie_nx;
      ovf    <= ovf_nx;
      flg    <= flg_nx;
      irq    <= (ovf_nx & ie_nx) | (|flg_nx);
    end
  end

  assign mode_q = {idle_gate, wdt, 3'b000, src, ovf_ie};
  assign ctrl_q = {ovf, run, {PAD{1'b0}}, flg};

  always_ff @(posedge clk) armed <= ~rst;

  // R9: overflow flag falls only under a control write of 0 to bit 7
  assert_ovf_sw_clear_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(ovf) |-> $past(ctrl_wr && !wr_data[CTRL_OVF]));

  // R10: a wrap always leaves the overflow flag set
  assert_ovf_hw_wins_R10: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf);

  // R10: an event always leaves its module flag set
  assert_flag_hw_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (|mod_evt) |=> ((flg & $past(mod_evt)) == $past(mod_evt)));

  // R11: masked overflow with no module flag requests nothing
  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst)
    (!ovf_ie && flg == '0) |-> !irq);
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pca_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_MOD  = 5,
  parameter int PRE_DIV  = 12,
  parameter int FAST_DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [7:0]         wr_data,
  input  logic               t0_ovf,
  input  logic               ext_pin,
  input  logic               idle,
  input  logic [NUM_MOD-1:0] mod_evt,
  output logic [7:0]         mode_q,
  output logic [7:0]         ctrl_q,
  output logic [CNT_W-1:0]   count_q,
  output logic               wdt_en,
  output logic               irq
);
  logic tick, wrap, count_en, run, gate;
  logic armed;

  assign run      = ctrl_q[CTRL_RUN];
  assign gate     = idle & mode_q[MODE_IDLE_GATE];
  assign count_en = run & ~gate;
  assign wdt_en   = mode_q[MODE_WDT];

  pca_src_sel #(.PRE_DIV(PRE_DIV), .FAST_DIV(FAST_DIV)) u_src (
    .clk    (clk),
    .rst    (rst),
    .src    (src_e'(mode_q[MODE_SRC_HI:MODE_SRC_LO])),
    .t0_ovf (t0_ovf),
    .ext_pin(ext_pin),
    .tick   (tick)
  );

  pca_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .en     (count_en),
    .count_q(count_q),
    .wrap   (wrap)
  );

  pca_regs #(.NUM_MOD(NUM_MOD)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .wrap   (wrap),
    .mod_evt(mod_evt),
    .mode_q (mode_q),
    .ctrl_q (ctrl_q),
    .irq    (irq)
  );

  always_ff @(posedge clk) armed <= ~rst;

  // R6: with the run bit clear the timebase holds
  assert_run_hold_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(run) |-> $stable(count_q));

  // R7: gated idle holds the timebase
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(gate) |-> $stable(count_q));
endmodule

// File: tb/sim_pca_timebase.sv
module sim_pca_timebase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        t0_ovf = 1'b0, ext_pin = 1'b1, idle = 1'b0;
  logic [4:0]  mod_evt = 5'h00;
  logic [7:0]  mode_q, ctrl_q;
  logic [15:0] count_q;
  logic        wdt_en, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pca_timebase u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .t0_ovf(t0_ovf), .ext_pin(ext_pin), .idle(idle), .mod_evt(mod_evt),
    .mode_q(mode_q), .ctrl_q(ctrl_q), .count_q(count_q), .wdt_en(wdt_en), .irq(irq)
  );

  // {mode, ctrl, idle, window end edge}
  localparam logic [31:0] VEC [8] = '{
    {8'h00, 8'h40, 8'd0, 8'd100},
    {8'h02, 8'h40, 8'd0, 8'd100},
    {8'h04, 8'h40, 8'd0, 8'd99},
    {8'h80, 8'h40, 8'd1, 8'd100},
    {8'h02, 8'h40, 8'd1, 8'd100},
    {8'h82, 8'h40, 8'd0, 8'd60},
    {8'h02, 8'h00, 8'd0, 8'd60},
    {8'h84, 8'h40, 8'd1, 8'd50}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cyc();
    rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  // expected count from R3/R4/R6/R7: edges 3..E, t0 high on multiples of 3
  function automatic int exp_count(input logic [7:0] m, input logic [7:0] c,
                                   input logic id, input int e);
    int dv;
    if (!c[6] || (id && m[7])) return 0;
    case (m[2:1])
      2'b00:   dv = 12;
      2'b01:   dv = 4;
      2'b10:   dv = 3;
      default: return 0;
    endcase
    return e / dv;
  endfunction

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 mode", mode_q, 8'h00);
    chk("R1 ctrl", ctrl_q, 8'h00);
    chk("R1 count", count_q, 16'h0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wdt", wdt_en, 1'b0);

    // vector table: R3 R4 R6 R7
    for (int v = 0; v < 8; v++) begin
      logic [7:0] m, c;
      int e;
      m = VEC[v][31:24]; c = VEC[v][23:16]; e = int'(VEC[v][7:0]);
      do_reset();
      idle = VEC[v][8];
      wr(1'b0, m);
      wr(1'b1, c);
      for (int k = 3; k <= e; k++) begin
        t0_ovf = (k % 3 == 0);
        cyc();
      end
      t0_ovf = 1'b0;
      chk($sformatf("R3/R4/R6/R7 vec%0d count", v), count_q, exp_count(m, c, idle, e));
      idle = 1'b0;
    end

    // R2 reserved bits and field layout
    do_reset();
    wr(1'b0, 8'hFF);
    chk("R2 mode rsvd", mode_q, 8'hC7);
    chk("R2 wdt_en", wdt_en, 1'b1);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h20);
    chk("R2 ctrl rsvd", ctrl_q, 8'h00);

    // R5 external pin, five slow falls
    do_reset();
    wr(1'b0, 8'h06);
    wr(1'b1, 8'h40);
    for (int f = 0; f < 5; f++) begin
      ext_pin = 1'b0; repeat (8) cyc();
      ext_pin = 1'b1; repeat (8) cyc();
    end
    repeat (16) cyc();
    chk("R5 ext count", count_q, 16'd5);

    // R9 R10 R11 module flags
    do_reset();
    mod_evt = 5'b00100; cyc(); mod_evt = 5'h00;
    chk("R9 flag set", ctrl_q, 8'h04);
    chk("R11 irq flag", irq, 1'b1);
    mod_evt = 5'b00100; wr(1'b1, 8'h00); mod_evt = 5'h00;
    chk("R10 flag wins", ctrl_q, 8'h04);
    wr(1'b1, 8'h00);
    chk("R9 flag clear", ctrl_q, 8'h00);
    chk("R11 irq drop", irq, 1'b0);
    wr(1'b1, 8'h1F);
    chk("R9 write1 no set", ctrl_q, 8'h00);
    wr(1'b1, 8'h80);
    chk("R9 sw set ovf", ctrl_q, 8'h80);
    chk("R11 ovf masked", irq, 1'b0);
    wr(1'b0, 8'h01);
    chk("R11 ovf enabled", irq, 1'b1);

    // R8 wrap via timer-0 every edge
    do_reset();
    wr(1'b0, 8'h04);
    t0_ovf = 1'b1;
    wr(1'b1, 8'h40);
    for (int g = 0; g < 70000 && count_q != 16'hFFFF; g++) cyc();
    chk("R8 pre-wrap ovf", ctrl_q[7], 1'b0);
    cyc();
    t0_ovf = 1'b0;
    chk("R8 wrap count", count_q, 16'h0);
    chk("R8 ovf set", ctrl_q[7], 1'b1);
    chk("R11 ovf no ie", irq, 1'b0);
    wr(1'b0, 8'h05);
    chk("R11 ovf ie", irq, 1'b1);
    wr(1'b1, 8'h40);
    chk("R9 ovf cleared", ctrl_q[7], 1'b0);
    chk("R11 irq cleared", irq, 1'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule